// File: doc/BRIEF.md
# Warp Load Coalescer

This block sits in front of an L1 data cache port that hands back one 64-byte line per cycle. It accepts a warp of per-thread byte addresses together with an active mask. It then serves the warp by fetching each distinct cache line exactly once, instead of once per thread. In every serving cycle it picks the line of the lowest-numbered thread still waiting and presents that line's tag to the cache. When the cache answers, every waiting thread whose address falls in that line takes its 32-bit word out of the returned line.

When the last waiting thread has its word, the block raises a one-cycle completion pulse. The per-thread results stay on the output until the next warp is accepted. The number of cache cycles a warp costs equals the number of unique lines its active threads touch. A warp whose active threads all hit one line is therefore served in a single cache cycle. The cache side is a plain request/response pair. The cache may hold back its response for any number of cycles, and the request stays put while it waits.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, in_ready is 1, req_valid is 0, out_done is 0 and out_data is all zero.
- R2: A warp is taken only on a cycle where in_valid and in_ready are both 1, and in_ready is 1 only while no warp is in progress. in_valid raised during service has no effect on the results of the warp in progress.
- R3: The line tag of a thread is address bits [31:6]. Each distinct tag among the active threads is requested exactly once, so the count of cycles with req_valid and rsp_valid both high equals the number of distinct active tags.
- R4: On every request, req_tag is the tag of the lowest-numbered active thread whose word has not yet been delivered.
- R5: With rsp_valid answering every request at once, out_done is high in the cycle following the cycle of the final response. A warp touching N distinct lines therefore reaches out_done N+1 cycles after the accepting clock edge, and a warp whose active threads share one line reaches it in 2.
- R6: Thread i's result occupies out_data bits [32i+31:32i]. It is the 32-bit word at position address[5:2] of its line, where word w occupies rsp_line bits [32w+31:32w].
- R7: Inactive threads cause no request, do not delay completion, and read back as zero in out_data.
- R8: While req_valid is high and rsp_valid is low, req_valid stays high and req_tag is unchanged on the next cycle, and no thread retires.
- R9: out_done is a single-cycle pulse. A warp with an all-zero active mask raises out_done in the cycle after it is accepted, with no request issued.
- R10: out_data keeps its values after out_done until another warp is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A warp is offered |
| in_ready | output | 1 | Unit idle, warp can be taken |
| in_active | input | LANES | Per-thread active mask |
| in_addr | input | LANES*32 | Per-thread byte addresses, thread i at [32i+31:32i] |
| req_valid | output | 1 | Line request to the cache |
| req_tag | output | 26 | Tag of the requested line |
| rsp_valid | input | 1 | Cache returns the requested line this cycle |
| rsp_line | input | 512 | Returned 64-byte line |
| out_data | output | LANES*32 | Per-thread loaded words |
| out_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the cache never answers without a pending request, and that rsp_line belongs to the tag currently presented. The assertions also assume that addresses are word-aligned. The bench cache model derives its response from req_tag in the same cycle, and gates it with a grant that can only answer an outstanding request. Every generated address has its low two bits at zero. An all-zero mask is never paired with in_valid held high after acceptance, so the bench never offers a second warp by accident while the unit is idle.

// File: rtl/warp_coal_pkg.sv
package warp_coal_pkg;

    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 64;
    localparam int WORD_BYTES = 4;

    localparam int WORD_W   = WORD_BYTES * 8;
    localparam int LINE_W   = LINE_BYTES * 8;
    localparam int WORDS    = LINE_BYTES / WORD_BYTES;
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int WORD_OFF = $clog2(WORD_BYTES);
    localparam int WSEL_W   = OFF_W - WORD_OFF;
    localparam int TAG_W    = ADDR_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic {ST_IDLE, ST_BUSY} coal_state_e;

    // Where a thread's word lives: which line and which word slot inside it.
    typedef struct packed {
        tag_t  tag;
        wsel_t wsel;
    } lane_ref_t;

    function automatic lane_ref_t split_addr(input addr_t a);
        lane_ref_t r;
        r.tag  = a[ADDR_W-1:OFF_W];
        r.wsel = a[OFF_W-1:WORD_OFF];
        return r;
    endfunction

endpackage

// File: rtl/wc_leader.sv
module wc_leader import warp_coal_pkg::*; #(
    parameter int LANES = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] pend,
    output logic             lead_ok,
    output logic [IDX_W-1:0] lead_idx
);

    // Lowest-numbered pending thread wins; scan from the top so it overwrites last.
    always_comb begin
        lead_ok  = |pend;
        lead_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) lead_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/wc_match.sv
module wc_match import warp_coal_pkg::*; #(
    parameter int LANES = 4
) (
    input  lane_ref_t        refs [LANES],
    input  logic [LANES-1:0] pend,
    input  tag_t             sel_tag,
    output logic [LANES-1:0] hit
);

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign hit[g] = pend[g] && (refs[g].tag == sel_tag);
    end

endmodule

// File: rtl/wc_steer.sv
module wc_steer import warp_coal_pkg::*; #(
    parameter int LANES = 4
) (
    input  line_t     line,
    input  lane_ref_t refs  [LANES],
    output word_t     words [LANES]
);

    for (genvar g = 0; g < LANES; g++) begin : g_mux
        assign words[g] = line[WORD_W * int'(refs[g].wsel) +: WORD_W];
    end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer import warp_coal_pkg::*; #(
    parameter int LANES = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANES-1:0]         in_active,
    input  logic [LANES*ADDR_W-1:0]  in_addr,
    output logic                     req_valid,
    output logic [TAG_W-1:0]         req_tag,
    input  logic                     rsp_valid,
    input  logic [LINE_W-1:0]        rsp_line,
    output logic [LANES*WORD_W-1:0]  out_data,
    output logic                     out_done
);

    coal_state_e      state_q;
    logic [LANES-1:0] pend_q;
    lane_ref_t        refs_q  [LANES];
    lane_ref_t        refs_in [LANES];
    word_t            data_q  [LANES];
    word_t            words   [LANES];
    logic             done_q;

    logic             lead_ok;
    logic [IDX_W-1:0] lead_idx;
    logic [LANES-1:0] hit;
    logic             accept;
    logic             fire;
    logic [LANES-1:0] pend_left;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign refs_in[g] = split_addr(in_addr[g*ADDR_W +: ADDR_W]);
        assign out_data[g*WORD_W +: WORD_W] = data_q[g];
    end

    wc_leader #(.LANES(LANES)) i_leader (
        .pend     (pend_q),
        .lead_ok  (lead_ok),
        .lead_idx (lead_idx)
    );

    wc_match #(.LANES(LANES)) i_match (
        .refs    (refs_q),
        .pend    (pend_q),
        .sel_tag (req_tag),
        .hit     (hit)
    );

    wc_steer #(.LANES(LANES)) i_steer (
        .line  (rsp_line),
        .refs  (refs_q),
        .words (words)
    );

    assign in_ready  = (state_q == ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign req_tag   = refs_q[lead_idx].tag;
    assign req_valid = (state_q == ST_BUSY) && lead_ok;
    assign fire      = req_valid && rsp_valid;
    assign pend_left = pend_q & ~hit;
    assign out_done  = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            done_q  <= 1'b0;
            for (int i = 0; i < LANES; i++) begin
                refs_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                for (int i = 0; i < LANES; i++) begin
                    refs_q[i] <= refs_in[i];
                    data_q[i] <= '0;
                end
                pend_q <= in_active;
                if (in_active == '0) begin
                    done_q <= 1'b1;
                end else begin
                    state_q <= ST_BUSY;
                end
            end else if (fire) begin
                for (int i = 0; i < LANES; i++) begin
                    if (hit[i]) data_q[i] <= words[i];
                end
                pend_q <= pend_left;
                if (pend_left == '0) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    AST_RSP_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_valid);                                           // R8
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_active != '0) |=> (!in_ready && req_valid)); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_tag)));     // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);                                            // R9
    AST_PEND_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> ((pend_q & ~$past(pend_q)) == '0));     // R7
    AST_LEADER_RETIRES: assert property (@(posedge clk) disable iff (rst)
        fire |-> hit[lead_idx]);                                            // R4
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !req_valid);                                           // R2

endmodule

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;
    import warp_coal_pkg::*;

    localparam int LANES = 4;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    in_valid;
    logic                    in_ready;
    logic [LANES-1:0]        in_active;
    logic [LANES*ADDR_W-1:0] in_addr;
    logic                    req_valid;
    logic [TAG_W-1:0]        req_tag;
    logic                    rsp_valid;
    logic [LINE_W-1:0]       rsp_line;
    logic [LANES*WORD_W-1:0] out_data;
    logic                    out_done;
    logic                    gnt;
    logic [15:0]             lfsr;

    int errs   = 0;
    int checks = 0;

    always #5 clk = ~clk;

    warp_coalescer #(.LANES(LANES)) i_warp_coalescer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_active(in_active), .in_addr(in_addr), .req_valid(req_valid),
        .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_line(rsp_line),
        .out_data(out_data), .out_done(out_done)
    );

    function automatic word_t mk_word(input tag_t t, input int w);
        return word_t'({t, wsel_t'(w)}) ^ 32'h9E37_5A00;
    endfunction

    // Cache model: answers the presented tag when granted.
    always_comb begin
        rsp_valid = req_valid & gnt;
        for (int w = 0; w < WORDS; w++) rsp_line[w*WORD_W +: WORD_W] = mk_word(req_tag, w);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic tag_t tag_of(input addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic run_warp(input logic [LANES-1:0] act, input addr_t a [LANES],
                            input bit stall, input bit junk);
        logic [LANES-1:0]        pend;
        logic [LANES*WORD_W-1:0] held;
        int cyc, grants, stalls, lines, lead;
        bit seen [LANES];
        while (!in_ready) @(negedge clk);
        in_valid  = 1'b1;
        in_active = act;
        for (int i = 0; i < LANES; i++) in_addr[i*ADDR_W +: ADDR_W] = a[i];
        gnt = 1'b1;
        // expected distinct lines among active threads
        lines = 0;
        for (int i = 0; i < LANES; i++) begin
            seen[i] = 1'b0;
            if (act[i]) begin
                bit dup = 1'b0;
                for (int j = 0; j < i; j++) if (act[j] && tag_of(a[j]) == tag_of(a[i])) dup = 1'b1;
                if (!dup) lines++;
            end
        end
        pend = act; cyc = 0; grants = 0; stalls = 0;
        @(negedge clk);
        if (junk && act != '0) begin
            in_active = '1;
            in_addr   = ~in_addr;
        end else begin
            in_valid = 1'b0;
        end
        forever begin
            if (stall) begin
                step_lfsr();
                gnt = lfsr[0] | lfsr[1];
            end
            #1;
            cyc++;
            if (out_done) break;
            if (req_valid) chk(!in_ready, "R2", "ready while serving", 64'(in_ready), 64'd0);
            if (req_valid && rsp_valid) begin
                lead = 0;
                for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
                chk(pend != '0 && req_tag == tag_of(a[lead]), "R4", "request tag",
                    64'(req_tag), 64'(tag_of(a[lead])));
                for (int i = 0; i < LANES; i++)
                    if (pend[i] && tag_of(a[i]) == req_tag) pend[i] = 1'b0;
                grants++;
            end else if (req_valid) begin
                stalls++;
            end
            if (cyc > 200) begin
                chk(1'b0, "R9", "done never seen", 64'(cyc), 64'(lines + 1));
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(grants == lines, "R3", "granted requests", 64'(grants), 64'(lines));
        chk(pend == '0, "R7", "threads left pending", 64'(pend), 64'd0);
        if (!stall)
            chk(cyc == lines + 1, "R5", "cycles to done", 64'(cyc), 64'(lines + 1));
        else
            chk(cyc == grants + stalls + 1, "R8", "cycles with stalls", 64'(cyc),
                64'(grants + stalls + 1));
        for (int i = 0; i < LANES; i++) begin
            word_t exp = act[i] ? mk_word(tag_of(a[i]), int'(a[i][OFF_W-1:WORD_OFF])) : '0;
            chk(out_data[i*WORD_W +: WORD_W] == exp, act[i] ? "R6" : "R7", "lane data",
                64'(out_data[i*WORD_W +: WORD_W]), 64'(exp));
        end
        held = out_data;
        @(negedge clk);
        #1;
        chk(!out_done, "R9", "done longer than one cycle", 64'(out_done), 64'd0);
        chk(out_data == held, "R10", "data not held", 64'(out_data), 64'(held));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL R9 watchdog act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        tag_t  tags [4];
        addr_t a    [LANES];
        rst = 1'b1; in_valid = 1'b0; in_active = '0; in_addr = '0; gnt = 1'b1;
        lfsr = 16'hACE1;
        tags[0] = 26'h100; tags[1] = 26'h101; tags[2] = 26'h2A7; tags[3] = 26'h3FF_FFFF;
        repeat (3) @(negedge clk);
        #1;
        chk(in_ready && !req_valid && !out_done && out_data == '0, "R1", "reset state",
            64'({in_ready, req_valid, out_done}), 64'h4);
        rst = 1'b0;
        @(negedge clk);
        // Sweep: every mask against every line assignment of the four threads.
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 256; p++) begin
                for (int i = 0; i < LANES; i++) begin
                    int d = (p >> (2 * i)) & 3;
                    a[i] = {tags[d], wsel_t'((i * 5 + p + m) & 15), 2'b00};
                end
                run_warp(LANES'(m), a, 1'b0, (p % 3) == 0);
            end
        end
        // Random patterns with a stalling cache.
        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < LANES; i++) begin
                step_lfsr();
                a[i] = {tags[lfsr[1:0]], lfsr[7:4], 2'b00};
            end
            step_lfsr();
            run_warp(lfsr[3:0], a, 1'b1, k[0]);
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule